// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned operands over several clock cycles and returns a double-width product as an upper word and a lower word. It needs one adder as wide as an operand and one register twice that wide. After the operands are taken in, the multiplier occupies the low half of that register and the upper half starts at zero. Every step looks at the register's least significant bit. If that bit is set, the multiplicand is added into the upper half. In the same clock, the whole register, together with the adder's carry, moves one place to the right. When every multiplier bit has been used, the upper half is the high word and the low half is the low word.

Operands come in over a valid/ready pair. `in_ready` is high exactly when the unit is idle. A transfer takes place on a rising edge where both `in_valid` and `in_ready` are high. While a multiply is in progress, `in_ready` is low and any `in_valid` is ignored, so the source has to hold its operands until `in_ready` returns. Results have no back-pressure. `done` is a one-cycle pulse, and `hi`/`lo` keep their value until the next transfer.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy`=0, `done`=0, `in_ready`=1, and `{hi,lo}` is zero.
- R2: `in_ready` equals the inverse of `busy`. An operand pair is accepted on a rising edge where `in_valid`=1 and `in_ready`=1. `busy` is 1 from the next cycle onward.
- R3: If operands are accepted at edge k, `done` is 1 only during the cycle that follows edge k+WIDTH. `busy` is 1 from edge k through edge k+WIDTH-1 and drops at edge k+WIDTH.
- R4: When `done` is 1, `{hi,lo}` equals the full 2×WIDTH-bit unsigned product of `mcand_i` and `mplier_i` as they were at acceptance. `hi` holds bits 2W-1..W and `lo` holds bits W-1..0.
- R5: No carry is lost. All-ones times all-ones gives hi = all-ones minus one and lo = 1.
- R6: A zero operand on either side gives a zero product. A one operand gives the other operand in `lo` and zero in `hi`.
- R7: `in_valid` pulses, with any operand values, while `busy`=1 have no effect on the running result or on its timing.
- R8: `done` never stays high for two cycles in a row. After `done`, `{hi,lo}` holds its value until the next acceptance.
- R9: A new pair can be accepted in the same cycle in which `done` is high, so consecutive multiplies need no idle cycle between them.
- R10: `busy` and `done` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Unit is idle and will take an operand pair |
| mcand_i | input | WIDTH | Multiplicand |
| mplier_i | input | WIDTH | Multiplier |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse: result valid |
| hi | output | WIDTH | Upper word of product |
| lo | output | WIDTH | Lower word of product |

## Verification
The embedded properties assume that `in_valid`, `mcand_i` and `mplier_i` carry known values on every edge after reset. They also assume the operands are sampled only at the accepting edge, so a source may change or hold them freely at any other time. The stimulus meets these assumptions by driving every input on falling edges only, keeping the operands steady through each accepting edge, and raising `in_valid` during busy periods only with deliberately different operands. These ignored requests give the properties that tie `busy`, the step count and the product register to the acceptance edge a clear check of the ignore rule.

// File: rtl/smul_pkg.sv
package smul_pkg;
  // Widths of the derived quantities for a WIDTH-bit operand
  function automatic int unsigned cnt_bits(input int unsigned width);
    return (width > 1) ? $clog2(width) : 1;
  endfunction
endpackage

// File: rtl/smul_adder.sv
module smul_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W:0]   s
);
  logic [W:0] c;
  assign c[0] = 1'b0;
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    assign s[gi]   = x[gi] ^ y[gi] ^ c[gi];
    assign c[gi+1] = (x[gi] & y[gi]) | (c[gi] & (x[gi] ^ y[gi]));
  end
  assign s[W] = c[W];
endmodule

// File: rtl/smul_seq.sv
module smul_seq
  import smul_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = cnt_bits(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic          busy_q, done_q, last;
  logic [CW-1:0] cnt_q;

  assign in_ready = ~busy_q;
  assign load     = in_valid & ~busy_q;
  assign step     = busy_q;
  assign last     = busy_q && (cnt_q == LAST);
  assign busy     = busy_q;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= last;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy_q && cnt_q == '0);
  assert_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done_q && !busy_q);
  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && in_valid && !last) |=> busy_q && cnt_q == CW'($past(cnt_q) + 1'b1));
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && busy_q));
endmodule

// File: rtl/smul_preg.sv
module smul_preg #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] hi,
  output logic [N-1:0] lo
);
  localparam int unsigned PW = 2 * N;

  logic [PW-1:0] prod_q;
  logic [N-1:0]  mcand_q, addend;
  logic [N:0]    sum;

  assign addend = prod_q[0] ? mcand_q : '0;

  smul_adder #(.W(N)) u_add (
    .x (prod_q[PW-1:N]),
    .y (addend),
    .s (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q  <= '0;
      mcand_q <= '0;
    end else if (load) begin
      prod_q  <= {{N{1'b0}}, b};
      mcand_q <= a;
    end else if (step) begin
      prod_q  <= {sum, prod_q[N-1:1]};
    end
  end

  assign hi = prod_q[PW-1:N];
  assign lo = prod_q[N-1:0];

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> lo == $past(b) && hi == '0);
  assert_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !prod_q[0]) |=> prod_q == ($past(prod_q) >> 1));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(prod_q));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  logic load, step;

  smul_seq #(.N(WIDTH)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .load     (load),
    .step     (step),
    .busy     (busy),
    .done     (done)
  );

  smul_preg #(.N(WIDTH)) u_preg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .a     (mcand_i),
    .b     (mplier_i),
    .hi    (hi),
    .lo    (lo)
  );

  assert_rdy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == !busy);
endmodule

// File: tb/sim_shift_add_mul.sv
module sim_shift_add_mul;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic in_ready, busy, done;
  logic [W-1:0] hi, lo;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;
  bit prev_done = 0;
  logic [2*W-1:0] last_res = '0;

  logic [2*W-1:0] exp_q[$];
  int             acc_q[$];
  string          tag_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  shift_add_mul #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mcand_i(a_i), .mplier_i(b_i), .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  task automatic check(input bit ok, input string req,
                       input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on the current falling edge; accept happens on the next rising edge
  task automatic drive_now(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    in_valid = 1'b1; a_i = a; b_i = b;
    exp_q.push_back({{W{1'b0}}, a} * {{W{1'b0}}, b});
    acc_q.push_back(cyc + 1 + W);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    drive_now(a, b, tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: scoreboard compare, R3 latency, R8 pulse, R10
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          check(0, "R3 unexpected done", {hi, lo}, '0);
        end else begin
          logic [2*W-1:0] e;
          int   ac;
          string t;
          e = exp_q.pop_front(); ac = acc_q.pop_front(); t = tag_q.pop_front();
          check({hi, lo} == e, t, {hi, lo}, e);
          check(cyc == ac, "R3 done cycle", 64'(cyc), 64'(ac));
          check(!busy, "R10 busy with done", 64'(busy), 64'd0);
          last_res = {hi, lo};
        end
        if (prev_done) check(0, "R8 done wider than one cycle", 64'd1, 64'd0);
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done && in_ready, "R1 flags", {61'd0, busy, done, in_ready}, 64'd1);
    check({hi, lo} == '0, "R1 product", {hi, lo}, '0);

    // R6 zero and one, R5 all ones, R4 small case
    send(32'd0, 32'hDEAD_BEEF, "R6 zero mcand");
    send(32'h1234_5678, 32'd0, "R6 zero mplier");
    send(32'd1, 32'hCAFE_F00D, "R6 one mcand");
    send(32'h8765_4321, 32'd1, "R6 one mplier");
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 all ones");
    send(32'hFFFF_FFFF, 32'd1, "R5 ones by one");
    send(32'd2, 32'd3, "R4 small");
    send(32'h8000_0000, 32'h8000_0000, "R4 top bits");
    drain();

    // R8 hold after done
    repeat (3) @(negedge clk);
    check({hi, lo} == last_res, "R8 hold", {hi, lo}, last_res);

    // R2 / R7: requests while busy are ignored
    send(32'h0BAD_F00D, 32'h1357_9BDF, "R7 result under ignored requests");
    @(negedge clk);
    check(!in_ready && busy, "R2 ready low when busy", {62'd0, in_ready, busy}, 64'd1);
    in_valid = 1'b1; a_i = 32'hFFFF_FFFF; b_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    drain();

    // R9 back-to-back acceptance in the done cycle
    send(32'h0000_ABCD, 32'h0000_1234, "R9 first");
    while (!done) @(negedge clk);
    check(in_ready, "R9 ready in done cycle", 64'(in_ready), 64'd1);
    drive_now(32'h7777_0001, 32'h0101_0101, "R9 second");
    drain();

    // R4 random operands
    for (int i = 0; i < 20; i++) begin
      send($urandom(), $urandom(), "R4 random");
    end
    drain();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule